// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller gathers up to 64 level-sensitive request lines and funnels them into two processor-facing request outputs, a fast one and a normal one. Each channel has its own enable bit and its own route-select bit, which sends it to one output or the other. Each channel also has a three-bit priority field. Every line that is seen high is held in a per-channel pending bit until software clears it.

For each output, a combinational arbiter picks the best enabled, pending channel routed to that output. The lowest effective level wins, and the lowest channel index breaks ties. One clock later the block registers two things: the output's request line, and an entry word equal to a software-programmed table base plus four times the winning index. An interrupt handler reads the entry word and jumps straight to the matching slot, so no software search for the source is needed. All configuration goes through a small synchronous word-addressed register bus with combinational read data.

Top module: `prio_vec_intc`

## Requirements
- R1: After synchronous reset both request outputs are low, and every register reads zero, including the two entry words.
- R2: A channel whose line is high at a clock edge has its pending bit set. The bit stays set after the line falls, until a 1 is written to it in the pending words (addresses 12 and 13, channel c at word c/32 bit c%32). If the line is still high, the clear has no effect and the bit stays set.
- R3: Enable words (addresses 0 and 1, channel c at word c/32 bit c%32, 1 = enabled). A disabled channel never drives a request output or an entry word, even while it is pending.
- R4: Route words (addresses 2 and 3, same bit layout as the enable words). A 1 sends the channel to the fast output and a 0 sends it to the normal output. A channel never affects the other output.
- R5: Priority words (addresses 4 to 11): channel c's field is bits 4*(c%8)+2 down to 4*(c%8) of word 4+c/8. For a fast-routed channel only bit 0 of the field counts, giving effective level 0 or 1.
- R6: For a normal-routed channel, field values 0 and 1 count as level 2, and values 2 to 7 count as themselves. On either output a lower effective level wins.
- R7: Among candidates with equal effective level on one output, the lowest channel index wins.
- R8: The fast entry word (address 15) and the normal entry word (address 16) read as table base (address 14) plus 4 times the winning index. An entry word reads zero when that output has no candidate. A request output is high exactly when its output has a candidate.
- R9: The request outputs and entry words reflect pending, enable, route, priority and base state one clock after that state changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_lines | input | 64 | Level-sensitive channel request lines |
| fast_req | output | 1 | Fast interrupt request to processor |
| norm_req | output | 1 | Normal interrupt request to processor |

## Verification
Faults in the masking, routing or level handling show up as a wrong winner. That means a wrong entry word, or a request on the wrong output, one clock after the offending configuration or line change. A broken pending latch shows as a request that vanishes when the line falls, or one that survives a clear. The sweeps compare both entry words against a winner that the bench computes from the configuration, over single-channel stimuli and over many mixed masks, routes and levels. They also sample the cycle before and the cycle after each change, to pin the one-clock latency.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
    parameter int unsigned CH_DEF  = 64;
    parameter int unsigned DATA_W  = 32;
    localparam int unsigned LVL_W  = 3;
    localparam int unsigned IDX_W  = 7;
    localparam int unsigned SLOT_SH = 2;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic {
        SEL_NORM = 1'b0,
        SEL_FAST = 1'b1
    } sel_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        lvl_t             lvl;
    } win_t;

    // Effective arbitration level: fast side keeps 0..1, normal side 2..7
    function automatic lvl_t eff_level(lvl_t raw, sel_e side);
        if (side == SEL_FAST)
            return {{(LVL_W-1){1'b0}}, raw[0]};
        else if (raw < lvl_t'(2))
            return lvl_t'(2);
        else
            return raw;
    endfunction
endpackage

// File: rtl/intc_regs.sv
module intc_regs
    import pvic_pkg::*;
#(
    parameter int unsigned NCH = CH_DEF,
    parameter int unsigned AW  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NCH-1:0]    lines,
    input  logic [DATA_W-1:0] fast_entry,
    input  logic [DATA_W-1:0] norm_entry,
    output logic [NCH-1:0]    en_q,
    output logic [NCH-1:0]    rt_q,
    output lvl_t              lvl_q [NCH],
    output logic [NCH-1:0]    pend_q,
    output logic [DATA_W-1:0] base_q
);
    localparam int unsigned NW     = NCH / DATA_W;
    localparam int unsigned PER_W  = DATA_W / 4;
    localparam int unsigned NP     = NCH / PER_W;
    localparam int unsigned A_EN   = 0;
    localparam int unsigned A_RT   = A_EN + NW;
    localparam int unsigned A_PR   = A_RT + NW;
    localparam int unsigned A_PD   = A_PR + NP;
    localparam int unsigned A_BASE = A_PD + NW;
    localparam int unsigned A_FE   = A_BASE + 1;
    localparam int unsigned A_NE   = A_FE + 1;

    logic [NCH-1:0] clr_v;

    always_comb begin
        clr_v = '0;
        for (int w = 0; w < NW; w++)
            if (wr && addr == AW'(A_PD + w))
                clr_v[w*DATA_W +: DATA_W] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            rt_q   <= '0;
            pend_q <= '0;
            base_q <= '0;
            for (int c = 0; c < NCH; c++) lvl_q[c] <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_v) | lines;
            for (int w = 0; w < NW; w++) begin
                if (wr && addr == AW'(A_EN + w)) en_q[w*DATA_W +: DATA_W] <= wdata;
                if (wr && addr == AW'(A_RT + w)) rt_q[w*DATA_W +: DATA_W] <= wdata;
            end
            for (int c = 0; c < NCH; c++)
                if (wr && addr == AW'(A_PR + c / PER_W))
                    lvl_q[c] <= wdata[4*(c % PER_W) +: LVL_W];
            if (wr && addr == AW'(A_BASE)) base_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < NW; w++) begin
            if (addr == AW'(A_EN + w)) rdata = en_q[w*DATA_W +: DATA_W];
            if (addr == AW'(A_RT + w)) rdata = rt_q[w*DATA_W +: DATA_W];
            if (addr == AW'(A_PD + w)) rdata = pend_q[w*DATA_W +: DATA_W];
        end
        for (int c = 0; c < NCH; c++)
            if (addr == AW'(A_PR + c / PER_W))
                rdata[4*(c % PER_W) +: LVL_W] = lvl_q[c];
        if (addr == AW'(A_BASE)) rdata = base_q;
        if (addr == AW'(A_FE))   rdata = fast_entry;
        if (addr == AW'(A_NE))   rdata = norm_entry;
    end

    AST_LEVEL_LATCH: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pend_q & $past(lines)) == $past(lines))) // R2
        else $error("line seen high did not set pending");
endmodule

// File: rtl/intc_arb.sv
module intc_arb
    import pvic_pkg::*;
#(
    parameter int unsigned NCH = CH_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] cand,
    input  lvl_t           lvl [NCH],
    output win_t           win
);
    always_comb begin
        win = '0;
        for (int c = 0; c < NCH; c++) begin
            if (cand[c] && (!win.hit || lvl[c] < win.lvl)) begin
                win.hit = 1'b1;
                win.idx = IDX_W'(c);
                win.lvl = lvl[c];
            end
        end
    end

    AST_WIN_IS_CAND: assert property (@(posedge clk) disable iff (rst)
        win.hit |-> cand[win.idx]) // R7
        else $error("winner is not a candidate");

    AST_HIT_IFF_CAND: assert property (@(posedge clk) disable iff (rst)
        (cand != '0) |-> win.hit) // R8
        else $error("candidates present but no winner");
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import pvic_pkg::*;
#(
    parameter int unsigned NCH = CH_DEF,
    parameter int unsigned AW  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    irq_lines,
    output logic              fast_req,
    output logic              norm_req
);
    localparam int unsigned NOUT = 2;

    logic [NCH-1:0]    en_q, rt_q, pend_q;
    lvl_t              lvl_q [NCH];
    logic [DATA_W-1:0] base_q;
    logic [DATA_W-1:0] entry_q [NOUT];
    logic              req_q   [NOUT];
    win_t              win     [NOUT];

    intc_regs #(.NCH(NCH), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .rdata(bus_rdata), .lines(irq_lines),
        .fast_entry(entry_q[SEL_FAST]), .norm_entry(entry_q[SEL_NORM]),
        .en_q(en_q), .rt_q(rt_q), .lvl_q(lvl_q), .pend_q(pend_q), .base_q(base_q)
    );

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        localparam sel_e SIDE = sel_e'(g);
        logic [NCH-1:0] cand;
        lvl_t           eff [NCH];

        assign cand = pend_q & en_q & ((SIDE == SEL_FAST) ? rt_q : ~rt_q);

        for (genvar c = 0; c < NCH; c++) begin : g_lvl
            assign eff[c] = eff_level(lvl_q[c], SIDE);
        end

        intc_arb #(.NCH(NCH)) u_arb (
            .clk(clk), .rst(rst), .cand(cand), .lvl(eff), .win(win[g])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= '0;
                req_q[g]   <= 1'b0;
            end else begin
                entry_q[g] <= win[g].hit
                    ? base_q + (DATA_W'(win[g].idx) << SLOT_SH) : '0;
                req_q[g]   <= win[g].hit;
            end
        end

        AST_WIN_ENABLED_ROUTED: assert property (@(posedge clk) disable iff (rst)
            win[g].hit |-> (en_q[win[g].idx] && (rt_q[win[g].idx] == (SIDE == SEL_FAST)))) // R3
            else $error("winner masked or misrouted");

        AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(win[g].hit)) |-> (!req_q[g] && entry_q[g] == '0)) // R8
            else $error("idle output not zero");
    end

    assign fast_req = req_q[SEL_FAST];
    assign norm_req = req_q[SEL_NORM];

    AST_ROUTE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(win[0].hit && win[1].hit && win[0].idx == win[1].idx)) // R4
        else $error("one channel won both outputs");
endmodule

// File: tb/sim_prio_vec_intc.sv
module sim_prio_vec_intc;
    localparam int PERIOD = 10;
    localparam int NCH = 64;
    localparam int A_EN = 0, A_RT = 2, A_PR = 4, A_PD = 12, A_BASE = 14, A_FE = 15, A_NE = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_lines = '0;
    logic        fast_req, norm_req;

    int n_chk = 0, n_fail = 0;
    logic [63:0] s_en, s_rt;
    logic [2:0]  s_lv [NCH];
    logic [31:0] s_base;

    always #(PERIOD/2) clk = ~clk;

    prio_vec_intc u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
        .fast_req(fast_req), .norm_req(norm_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 5'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic push_cfg();
        logic [31:0] w;
        wr(A_EN, s_en[31:0]);  wr(A_EN+1, s_en[63:32]);
        wr(A_RT, s_rt[31:0]);  wr(A_RT+1, s_rt[63:32]);
        for (int p = 0; p < 8; p++) begin
            w = '0;
            for (int k = 0; k < 8; k++) w[4*k +: 3] = s_lv[p*8+k];
            wr(A_PR + p, w);
        end
        wr(A_BASE, s_base);
    endtask

    // Expected entry for one side, with pending = given vector
    function automatic logic [31:0] exp_entry(input logic fast, input logic [63:0] pend);
        int best, bl, el;
        best = -1; bl = 99;
        for (int c = 0; c < NCH; c++) begin
            if (pend[c] && s_en[c] && (s_rt[c] == fast)) begin
                if (fast) el = int'(s_lv[c][0]);
                else el = (s_lv[c] < 2) ? 2 : int'(s_lv[c]);
                if (el < bl) begin bl = el; best = c; end
            end
        end
        return (best < 0) ? 32'h0 : s_base + 32'(best * 4);
    endfunction

    task automatic check_outputs(input string req, input logic [63:0] pend);
        logic [31:0] d, ef, en;
        ef = exp_entry(1'b1, pend);
        en = exp_entry(1'b0, pend);
        rd(A_FE, d); chk(req, d, ef);
        rd(A_NE, d); chk(req, d, en);
        chk(req, 32'(fast_req), 32'(ef != 0 || (pend & s_en & s_rt) != 0));
        chk(req, 32'(norm_req), 32'((pend & s_en & ~s_rt) != 0));
    endtask

    task automatic clear_all();
        irq_lines = '0;
        wr(A_PD, 32'hFFFF_FFFF);
        wr(A_PD+1, 32'hFFFF_FFFF);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(PERIOD * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [63:0] ln;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1", 32'(fast_req), 0);
        chk("R1", 32'(norm_req), 0);
        for (int a = 0; a <= A_NE; a++) begin rd(a, d); chk("R1", d, 0); end

        // R4/R8/R9: single-channel sweep, odd channels fast
        s_en = '1; s_rt = {32{2'b10}}; s_base = 32'h0000_4000;
        for (int c = 0; c < NCH; c++) s_lv[c] = '0;
        push_cfg();
        for (int c = 0; c < NCH; c++) begin
            ln = 64'd1 << c;
            irq_lines = ln;
            @(negedge clk);
            chk("R9", 32'(fast_req | norm_req), 0);
            @(negedge clk);
            check_outputs("R8", ln);
            rd(A_PD + c/32, d); chk("R2", 32'(d[c%32]), 1);
            clear_all();
            chk("R9", 32'(fast_req | norm_req), 0);
            rd(c[0] ? A_FE : A_NE, d); chk("R8", d, 0);
        end

        // R2: clear while line active leaves pending; clear after release works
        irq_lines = 64'd1 << 7;
        @(negedge clk);
        wr(A_PD, 32'h80);
        rd(A_PD, d); chk("R2", 32'(d[7]), 1);
        irq_lines = '0;
        @(negedge clk);
        rd(A_PD, d); chk("R2", 32'(d[7]), 1);
        wr(A_PD, 32'h80);
        rd(A_PD, d); chk("R2", 32'(d[7]), 0);
        @(negedge clk);

        // R3: masked channel pending never drives output
        s_en = ~(64'd1 << 20);
        push_cfg();
        irq_lines = 64'd1 << 20;
        repeat (2) @(negedge clk);
        chk("R3", 32'(fast_req | norm_req), 0);
        rd(A_NE, d); chk("R3", d, 0);
        rd(A_PD, d); chk("R3", 32'(d[20]), 1);
        // R9: enabling it appears one clock later
        s_en = '1;
        wr(A_EN, 32'hFFFF_FFFF);
        chk("R9", 32'(norm_req), 0);
        @(negedge clk);
        chk("R9", 32'(norm_req), 1);
        rd(A_NE, d); chk("R9", d, s_base + 32'd80);
        clear_all();

        // R5/R6/R7: level field interpretation and ties
        s_rt = '0; s_rt[9] = 1'b1; s_rt[40] = 1'b1;
        for (int c = 0; c < NCH; c++) s_lv[c] = 3'd7;
        s_lv[9] = 3'd1; s_lv[40] = 3'd6;          // fast: 40 has effective 0
        s_lv[1] = 3'd2; s_lv[3] = 3'd0;           // normal: both effective 2, tie
        push_cfg();
        ln = '0; ln[9] = 1; ln[40] = 1; ln[1] = 1; ln[3] = 1;
        irq_lines = ln;
        repeat (2) @(negedge clk);
        rd(A_FE, d); chk("R5", d, s_base + 32'd160);
        rd(A_NE, d); chk("R7", d, s_base + 32'd4);
        s_lv[1] = 3'd3;
        wr(A_PR, {16'h0, 4'h0, 4'h0, 4'h3, 4'h7} | 32'h7777_0000);
        @(negedge clk);
        rd(A_NE, d); chk("R6", d, s_base + 32'd12);
        clear_all();

        // R3..R8: mixed pattern sweeps against computed winners
        for (int k = 0; k < 24; k++) begin
            for (int c = 0; c < NCH; c++) begin
                s_en[c] = ((c * 7 + k) % 5) != 0;
                s_rt[c] = ((c + k) % 3) == 0;
                s_lv[c] = 3'((c * (k + 3) + k) % 8);
                ln[c]   = ((c + 2 * k) % 4 != 3) && (((c ^ k) % 7) != 2);
            end
            s_base = 32'h1000 * (k + 1) + 32'(k * 16);
            push_cfg();
            irq_lines = ln;
            repeat (2) @(negedge clk);
            check_outputs("R6", ln);
            clear_all();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule